// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square N×N matrices of signed integers (N = 3 and 8-bit operands by default) on a grid of N×N multiply-accumulate cells. Each cell owns one element of the product and keeps it in a local accumulator. Elements of the left matrix travel rightwards along the grid rows and elements of the right matrix travel downwards along the grid columns. Every cell multiplies the pair of operands that reaches it, adds the product to its accumulator, and passes both operands on to its neighbours one clock later.

A start pulse captures both input matrices whole. It clears every accumulator and every pipeline stage. It then launches an on-chip feeder that drives column k of the left matrix and row k of the right matrix onto the grid edges on feed step k. The edges are staggered so that grid row i is delayed by i cycles and grid column j by j cycles. Because of this stagger, a(i,k) and b(k,j) reach cell (i,j) in the same cycle. The whole product is ready 3N−2 cycles after the first feed step. It stays in the grid and can be read one element at a time through an index/data port.

Top module: `sysmm_top`

## Requirements
- R1: After reset, done and busy are 0 and rd_data reads 0 for every index.
- R2: If start is sampled at clock edge E, busy is 1 and done is 0 from E until edge E+3N−2. At that edge done rises and busy falls.
- R3: When done is 1, element (i,j) holds the exact signed sum over k of a(i,k)·b(k,j). This also holds when every operand is −128 or 127, because the accumulators are 2W+ceil(log2 N) bits wide.
- R4: Matrix element (r,c) of a_mat, b_mat and of the readout sits at flat index r·N+c, that is, bits [(r·N+c)·W +: W] of the inputs. rd_data shows element rd_idx combinationally, and any index of N·N or more reads 0.
- R5: A start pulse clears all results, so a run never carries over sums from an earlier product.
- R6: a_mat and b_mat are sampled only on the start edge. Changing them later does not affect the running product or the held result.
- R7: A start during a run abandons that run. Operands already in flight are discarded, and done then follows the timing of R2 from the new start, with the product of the new matrices.
- R8: After done, the result and done stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: capture matrices, clear, run |
| a_mat | input | N·N·W | Left matrix, row-major, signed elements |
| b_mat | input | N·N·W | Right matrix, row-major, signed elements |
| busy | output | 1 | Product in progress |
| done | output | 1 | Product complete and held |
| rd_idx | input | ceil(log2(N·N)) | Row-major result index |
| rd_data | output | 2W+ceil(log2 N) | Signed result element at rd_idx |

## Verification
The assertions check on every cycle that the two operand valids meet each cell in the same cycle, that a cell with no valid operands leaves its accumulator unchanged, and that a start clears every accumulator and pipeline stage. They also check that the edge stagger carries only zeros when idle, that busy and done never overlap, and that a held done persists. Only the bench scenarios can show the arithmetic against a reference triple-loop product: the identity, extreme-value and random matrices. The same holds for the exact cycle on which done rises, the restart behaviour and the readout mapping.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  function automatic int acc_width(input int w, input int n);
    return 2 * w + $clog2(n);
  endfunction

  function automatic int run_cycles(input int n);
    return 3 * n - 2;
  endfunction
endpackage

// File: rtl/sysmm_skew.sv
module sysmm_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d_in,
  input  logic         v_in,
  output logic [W-1:0] d_out,
  output logic         v_out
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign d_out = d_in;
      assign v_out = v_in;
    end else begin : g_line
      logic [W-1:0] d_q [DEPTH];
      logic         v_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < DEPTH; s++) begin
            d_q[s] <= '0;
            v_q[s] <= 1'b0;
          end
        end else if (clr) begin
          for (int s = 0; s < DEPTH; s++) begin
            d_q[s] <= '0;
            v_q[s] <= 1'b0;
          end
        end else begin
          d_q[0] <= v_in ? d_in : '0;
          v_q[0] <= v_in;
          for (int s = 1; s < DEPTH; s++) begin
            d_q[s] <= d_q[s-1];
            v_q[s] <= v_q[s-1];
          end
        end
      end
      assign d_out = d_q[DEPTH-1];
      assign v_out = v_q[DEPTH-1];

      assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !v_out |-> d_out == '0);
    end
  endgenerate
endmodule

// File: rtl/sysmm_pe.sv
module sysmm_pe #(
  parameter int W  = 8,
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [W-1:0]  a_in,
  input  logic          va_in,
  input  logic [W-1:0]  b_in,
  input  logic          vb_in,
  output logic [W-1:0]  a_out,
  output logic          va_out,
  output logic [W-1:0]  b_out,
  output logic          vb_out,
  output logic [AW-1:0] acc
);
  function automatic logic [AW-1:0] mac(input logic [AW-1:0] sum,
                                        input logic [W-1:0] x,
                                        input logic [W-1:0] y);
    logic signed [2*W-1:0] prod;
    prod = $signed(x) * $signed(y);
    return sum + AW'(prod);
  endfunction

  logic mac_fire;
  assign mac_fire = va_in && vb_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      a_out  <= '0;
      b_out  <= '0;
      va_out <= 1'b0;
      vb_out <= 1'b0;
    end else if (clr) begin
      acc    <= '0;
      a_out  <= '0;
      b_out  <= '0;
      va_out <= 1'b0;
      vb_out <= 1'b0;
    end else begin
      if (mac_fire) acc <= mac(acc, a_in, b_in);
      a_out  <= a_in;
      b_out  <= b_in;
      va_out <= va_in;
      vb_out <= vb_in;
    end
  end

  assert_operands_meet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    va_in == vb_in);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!va_in && !clr) |=> $stable(acc));
  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0 && !va_out && !vb_out));
endmodule

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl #(
  parameter int N = 3,
  localparam int RUN = sysmm_pkg::run_cycles(N),
  localparam int CW  = $clog2(RUN + 1),
  localparam int SW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          feed_en,
  output logic [SW-1:0] feed_step,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(RUN - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign feed_en   = busy && (cnt < CW'(N));
  assign feed_step = SW'(cnt);

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));
  assert_done_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top #(
  parameter int W = 8,
  parameter int N = 3,
  localparam int AW = sysmm_pkg::acc_width(W, N),
  localparam int EL = N * N,
  localparam int IW = $clog2(EL),
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [EL*W-1:0] a_mat,
  input  logic [EL*W-1:0] b_mat,
  output logic            busy,
  output logic            done,
  input  logic [IW-1:0]   rd_idx,
  output logic [AW-1:0]   rd_data
);
  logic [EL*W-1:0] a_q, b_q;
  logic            feed_en;
  logic [SW-1:0]   feed_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (start) begin
      a_q <= a_mat;
      b_q <= b_mat;
    end
  end

  sysmm_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .feed_en(feed_en), .feed_step(feed_step), .busy(busy), .done(done)
  );

  logic [W-1:0] a_h [N][N+1];
  logic         va_h[N][N+1];
  logic [W-1:0] b_v [N+1][N];
  logic         vb_v[N+1][N];
  logic [AW-1:0] acc_arr [EL];

  for (genvar i = 0; i < N; i++) begin : g_edge
    logic [W-1:0] a_src, b_src;
    assign a_src = feed_en ? a_q[(i*N + int'(feed_step))*W +: W] : '0;
    assign b_src = feed_en ? b_q[(int'(feed_step)*N + i)*W +: W] : '0;

    sysmm_skew #(.W(W), .DEPTH(i)) u_skew_a (
      .clk(clk), .rst_n(rst_n), .clr(start),
      .d_in(a_src), .v_in(feed_en), .d_out(a_h[i][0]), .v_out(va_h[i][0])
    );
    sysmm_skew #(.W(W), .DEPTH(i)) u_skew_b (
      .clk(clk), .rst_n(rst_n), .clr(start),
      .d_in(b_src), .v_in(feed_en), .d_out(b_v[0][i]), .v_out(vb_v[0][i])
    );
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      sysmm_pe #(.W(W), .AW(AW)) u_pe (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .a_in(a_h[r][c]), .va_in(va_h[r][c]),
        .b_in(b_v[r][c]), .vb_in(vb_v[r][c]),
        .a_out(a_h[r][c+1]), .va_out(va_h[r][c+1]),
        .b_out(b_v[r+1][c]), .vb_out(vb_v[r+1][c]),
        .acc(acc_arr[r*N + c])
      );
    end
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < EL; e++)
      if (rd_idx == IW'(e)) rd_data = acc_arr[e];
  end

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/test_sysmm_top.sv
module test_sysmm_top;
  localparam int W  = 8;
  localparam int N  = 3;
  localparam int EL = N * N;
  localparam int AW = 2 * W + $clog2(N);
  localparam int IW = $clog2(EL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [EL*W-1:0] a_mat = '0, b_mat = '0;
  logic busy, done;
  logic [IW-1:0] rd_idx = '0;
  logic [AW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int ma [N][N];
  int mb [N][N];
  int ref_c [N][N];

  always #4 clk = ~clk;

  sysmm_top #(.W(W), .N(N)) i_sysmm_top (
    .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat), .b_mat(b_mat),
    .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pack_mats();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        a_mat[(r*N+c)*W +: W] = W'(ma[r][c]);
        b_mat[(r*N+c)*W +: W] = W'(mb[r][c]);
      end
  endtask

  task automatic ref_product();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ref_c[i][j] = 0;
        for (int k = 0; k < N; k++) ref_c[i][j] += ma[i][k] * mb[k][j];
      end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd_idx = IW'(i*N + j);
        #1;
        check(req, $sformatf("c[%0d][%0d]", i, j), int'($signed(rd_data)), ref_c[i][j]);
      end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
  endtask

  // R2: done rises on the edge 3N-2 after the start edge
  task automatic wait_done_timed(input string tag);
    int busy_bad = 0;
    int done_bad = 0;
    for (int k = 1; k < 3*N - 2; k++) begin
      if (!busy) busy_bad++;
      if (done) done_bad++;
      @(negedge clk);
    end
    if (!busy) busy_bad++;
    if (done) done_bad++;
    check("R2", {tag, " busy before finish"}, busy_bad, 0);
    check("R2", {tag, " done before finish"}, done_bad, 0);
    @(negedge clk);
    check("R2", {tag, " done at 3N-2"}, int'(done), 1);
    check("R2", {tag, " busy low at 3N-2"}, int'(busy), 0);
  endtask

  task automatic run_case(input string tag, input string req);
    pack_mats();
    ref_product();
    pulse_start();
    wait_done_timed(tag);
    read_all(req);
  endtask

  task automatic t_reset();
    check("R1", "done after reset", int'(done), 0);
    check("R1", "busy after reset", int'(busy), 0);
    for (int e = 0; e < EL; e++) begin
      rd_idx = IW'(e); #1;
      check("R1", $sformatf("rd_data[%0d]", e), int'(rd_data), 0);
    end
  endtask

  task automatic t_identity();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i == j) ? 1 : 0;
        mb[i][j] = i*N + j - 4;
      end
    run_case("identity", "R3");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = -128; mb[i][j] = -128; end
    run_case("all -128", "R3");
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 127; mb[i][j] = -128; end
    run_case("127 x -128", "R5");
  endtask

  task automatic t_rowmajor();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = i*N + j + 1; mb[i][j] = (j == 0) ? 1 : 0; end
    run_case("layout", "R4");
    for (int e = EL; e < (1 << IW); e++) begin
      rd_idx = IW'(e); #1;
      check("R4", $sformatf("out-of-range idx %0d", e), int'(rd_data), 0);
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          ma[i][j] = int'($urandom_range(0, 255)) - 128;
          mb[i][j] = int'($urandom_range(0, 255)) - 128;
        end
      run_case($sformatf("random %0d", n), "R3");
    end
  endtask

  task automatic t_hold();
    a_mat = '1; b_mat = '1;
    repeat (10) @(negedge clk);
    check("R8", "done held", int'(done), 1);
    read_all("R6");
  endtask

  task automatic t_restart();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 100; mb[i][j] = 90; end
    pack_mats();
    pulse_start();
    @(negedge clk);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = i - j; mb[i][j] = i + 2*j - 3; end
    pack_mats();
    ref_product();
    pulse_start();
    a_mat = '0; b_mat = '0;
    wait_done_timed("restart");
    read_all("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_identity();
    t_extremes();
    t_rowmajor();
    t_random();
    t_hold();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule